// File: doc/BRIEF.md
# Masked Interrupt Aggregator

This block gathers six peripheral interrupt requests into one interrupt line for the CPU. Each source has a pending flag and an enable (mask) flag. The CPU interrupt is raised when at least one source is both pending and enabled. The sources sit in a fixed bit order: 0 signal processor, 1 serial, 2 audio, 3 video, 4 parallel, 5 display processor.

The CPU changes the masks through a word-addressed write port. In a mask write, each source has a pair of bits, one that clears its mask and one that sets it. No write loads the mask as a plain value. Sources 0 to 4 carry level requests: their peripherals raise and drop them, so acknowledging one happens inside the peripheral. Source 5 arrives as a single-cycle pulse and is held here until the CPU writes the acknowledge bit of the mode register. The mask and pending flags are brought out as plain bit vectors for the read path.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every mask flag, every pending flag and `cpu_irq` are 0.
- R2: A write to word address 3 (mask register) with data bit 2n = 1 and bit 2n+1 = 0 clears the mask of source n (n = 0..5) at that clock edge.
- R3: A write to word address 3 with data bit 2n+1 = 1 and bit 2n = 0 sets the mask of source n at that clock edge.
- R4: In a mask write, a source whose two bits are both 1 or both 0 keeps its mask value.
- R5: `mask_view` bit n is the mask of source n, and `pend_view` bit n is the pending flag of source n.
- R6: For sources 0 to 4, `pend_view[n]` is `src_level[n]` as sampled at the previous clock edge.
- R7: A one-cycle pulse on `dp_pulse` sets pending flag 5 at that edge. The flag stays at 1 until it is cleared.
- R8: A write to word address 0 (mode register) with data bit 11 = 1 clears pending flag 5. Other mode bits leave it unchanged. If the pulse and the clear fall on the same edge, the flag is set.
- R9: `cpu_irq` is registered. It equals the OR over all sources of (pending AND mask), as those flags stood one clock earlier.
- R10: Writes to word addresses 1 and 2 change neither the masks nor pending flag 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address: 0 mode, 3 mask |
| reg_wdata | input | 32 | Write data |
| src_level | input | 5 | Level requests of sources 0 to 4 |
| dp_pulse | input | 1 | Request pulse of source 5 |
| mask_view | output | 6 | Mask flags, bit n = source n |
| pend_view | output | 6 | Pending flags, bit n = source n |
| cpu_irq | output | 1 | Registered CPU interrupt |

## Verification
A register write, a level change or a pulse shows up on `mask_view` and `pend_view` after exactly one clock edge. `cpu_irq` follows one edge after that, so it is due two edges after the stimulus. The bench drives every input on the falling edge. It reads the views one full cycle later, and it reads `cpu_irq` after one further cycle. Each check also looks at the cycle before the result is due, so an output that arrives a cycle early is reported as well.

// File: rtl/irq_agg_pkg.sv
// Package: shared sizes and register word addresses of the interrupt aggregator.
// Assumes: a word-addressed write port with 2 address bits.
package irq_agg_pkg;
    localparam int NUM_SRC     = 6;
    localparam int ADDR_W      = 2;
    localparam int DATA_W      = 32;
    localparam int DP_ACK_BIT  = 11;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_MODE = 2'd0,
        ADDR_RSV1 = 2'd1,
        ADDR_RSV2 = 2'd2,
        ADDR_MASK = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/irq_reg_decode.sv
// Module: turns a register write into per-source mask clear/set strobes
// and the display-processor acknowledge strobe.
// Assumes: writes are single-cycle strobes; the decode is purely combinational.
module irq_reg_decode
    import irq_agg_pkg::*;
#(
    parameter int N_SRC   = NUM_SRC,
    parameter int AW      = ADDR_W,
    parameter int DW      = DATA_W,
    parameter int ACK_BIT = DP_ACK_BIT
) (
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [N_SRC-1:0] clr_stb,
    output logic [N_SRC-1:0] set_stb,
    output logic          ack_stb
);
    logic mask_hit;
    logic mode_hit;

    // Address match for the two registers this block owns.
    always_comb begin
        mask_hit = wr && (addr == AW'(ADDR_MASK));
        mode_hit = wr && (addr == AW'(ADDR_MODE));
        ack_stb  = mode_hit && wdata[ACK_BIT];
    end

    for (genvar n = 0; n < N_SRC; n++) begin : g_pair
        // A pair with both bits equal is a no-op for that source.
        always_comb begin
            clr_stb[n] = mask_hit &&  wdata[2*n] && !wdata[2*n+1];
            set_stb[n] = mask_hit && !wdata[2*n] &&  wdata[2*n+1];
        end
    end
endmodule

// File: rtl/irq_mask_bank.sv
// Module: holds one mask flag per source, updated by clear/set strobes.
// Assumes: clear and set for the same source are never both asserted
// (the decoder filters that case out).
module irq_mask_bank #(
    parameter int N_SRC = irq_agg_pkg::NUM_SRC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] clr_stb,
    input  logic [N_SRC-1:0] set_stb,
    output logic [N_SRC-1:0] mask_q
);
    for (genvar n = 0; n < N_SRC; n++) begin : g_mask
        // Per-source mask flag with synchronous reset to disabled.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mask_q[n] <= 1'b0;
            else if (set_stb[n])
                mask_q[n] <= 1'b1;
            else if (clr_stb[n])
                mask_q[n] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_pending_bank.sv
// Module: pending flags. Every source but the last follows its level request.
// The last source is a sticky latch set by a pulse and cleared by an acknowledge.
// Assumes: level inputs are synchronous to clk.
module irq_pending_bank #(
    parameter int N_SRC = irq_agg_pkg::NUM_SRC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-2:0] level_in,
    input  logic             pulse_in,
    input  logic             ack_in,
    output logic [N_SRC-1:0] pend_q
);
    localparam int LATCH_IDX = N_SRC - 1;

    for (genvar n = 0; n < N_SRC; n++) begin : g_pend
        if (n == LATCH_IDX) begin : g_sticky
            // Sticky flag: a pulse wins over an acknowledge on the same edge.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    pend_q[n] <= 1'b0;
                else if (pulse_in)
                    pend_q[n] <= 1'b1;
                else if (ack_in)
                    pend_q[n] <= 1'b0;
            end
        end else begin : g_level
            // Level flag: registered copy of the peripheral request.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    pend_q[n] <= 1'b0;
                else
                    pend_q[n] <= level_in[n];
            end
        end
    end
endmodule

// File: rtl/irq_aggregator.sv
// Module: top of the masked interrupt aggregator. Decodes register writes,
// keeps mask and pending flags, and drives a registered CPU interrupt.
// Assumes: synchronous active-low reset; all inputs synchronous to clk.
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int AW    = ADDR_W,
    parameter int DW    = DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [AW-1:0]    reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    input  logic [N_SRC-2:0] src_level,
    input  logic             dp_pulse,
    output logic [N_SRC-1:0] mask_view,
    output logic [N_SRC-1:0] pend_view,
    output logic             cpu_irq
);
    logic [N_SRC-1:0] clr_stb;
    logic [N_SRC-1:0] set_stb;
    logic             ack_stb;

    irq_reg_decode #(.N_SRC(N_SRC), .AW(AW), .DW(DW)) u_dec (
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .clr_stb (clr_stb),
        .set_stb (set_stb),
        .ack_stb (ack_stb)
    );

    irq_mask_bank #(.N_SRC(N_SRC)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_stb (clr_stb),
        .set_stb (set_stb),
        .mask_q  (mask_view)
    );

    irq_pending_bank #(.N_SRC(N_SRC)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (src_level),
        .pulse_in (dp_pulse),
        .ack_in   (ack_stb),
        .pend_q   (pend_view)
    );

    // Registered CPU interrupt: any pending and enabled source.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cpu_irq <= 1'b0;
        else
            cpu_irq <= |(pend_view & mask_view);
    end
endmodule

// File: rtl/irq_aggregator_chk.sv
// Module: checker bound to irq_aggregator; relates port activity across cycles.
// Assumes: bound through the bind below, with default parameters.
module irq_aggregator_chk #(
    parameter int N_SRC = irq_agg_pkg::NUM_SRC
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic             dp_pulse,
    input logic [N_SRC-1:0] mask_view,
    input logic [N_SRC-1:0] pend_view,
    input logic             cpu_irq
);
    for (genvar n = 0; n < N_SRC; n++) begin : g_src
        // R3
        mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_addr == 2'd3 && reg_wdata[2*n+1] && !reg_wdata[2*n]) |=> mask_view[n]);
        // R2
        mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_addr == 2'd3 && reg_wdata[2*n] && !reg_wdata[2*n+1]) |=> !mask_view[n]);
        // R4
        mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_addr == 2'd3 && (reg_wdata[2*n] == reg_wdata[2*n+1])) |=> $stable(mask_view[n]));
    end

    // R10
    mask_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == 2'd3) |=> $stable(mask_view));

    // R7
    dp_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dp_pulse |=> pend_view[N_SRC-1]);

    // R8
    dp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dp_pulse && !(reg_wr && reg_addr == 2'd0 && reg_wdata[11])) |=> $stable(pend_view[N_SRC-1]));

    // R9
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_irq) |-> $past((pend_view & mask_view) != '0));
endmodule

bind irq_aggregator irq_aggregator_chk #(.N_SRC(N_SRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .dp_pulse  (dp_pulse),
    .mask_view (mask_view),
    .pend_view (pend_view),
    .cpu_irq   (cpu_irq)
);

// File: tb/irq_aggregator_tb.sv
// Bench: directed scenarios for irq_aggregator, one task each.
module irq_aggregator_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [4:0]  src_level = '0;
    logic        dp_pulse = 1'b0;
    logic [5:0]  mask_view;
    logic [5:0]  pend_view;
    logic        cpu_irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    irq_aggregator dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .src_level(src_level), .dp_pulse(dp_pulse),
        .mask_view(mask_view), .pend_view(pend_view), .cpu_irq(cpu_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One register write; returns on the falling edge after it took effect.
    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic t_reset;
        check("R1 mask", {26'd0, mask_view}, 32'd0);
        check("R1 pend", {26'd0, pend_view}, 32'd0);
        check("R1 irq",  {31'd0, cpu_irq}, 32'd0);
    endtask

    task automatic t_mask_set_clear;
        wr_reg(2'd3, 32'b10_00_10_00_10_10);   // set 0,1,3,5
        check("R3 R5 set view", {26'd0, mask_view}, 32'b101011);
        wr_reg(2'd3, 32'b01_00_00_00_00_01);   // clear 0,5
        check("R2 R5 clear view", {26'd0, mask_view}, 32'b001010);
    endtask

    task automatic t_mask_pair_hold;
        wr_reg(2'd3, 32'b00_00_11_11_11_00);   // 1,2,3 both; 0,4,5 neither
        check("R4 pair hold", {26'd0, mask_view}, 32'b001010);
    endtask

    task automatic t_level_follow;
        src_level = 5'b10101;
        check("R6 not early", {26'd0, pend_view}, 32'd0);
        @(negedge clk);
        check("R6 follow", {26'd0, pend_view}, 32'b010101);
        src_level = 5'b00000;
        @(negedge clk);
        check("R6 drop", {26'd0, pend_view}, 32'd0);
    endtask

    task automatic t_dp_latch;
        dp_pulse = 1'b1;
        @(negedge clk);
        dp_pulse = 1'b0;
        check("R7 set", {31'd0, pend_view[5]}, 32'd1);
        repeat (3) @(negedge clk);
        check("R7 held", {31'd0, pend_view[5]}, 32'd1);
    endtask

    task automatic t_dp_clear;
        wr_reg(2'd0, 32'hFFFF_F7FF);           // all mode bits except ack
        check("R8 other bits", {31'd0, pend_view[5]}, 32'd1);
        dp_pulse = 1'b1;
        wr_reg(2'd0, 32'h0000_0800);           // clear with pulse
        dp_pulse = 1'b0;
        check("R8 pulse wins", {31'd0, pend_view[5]}, 32'd1);
        wr_reg(2'd0, 32'h0000_0800);
        check("R8 clear", {31'd0, pend_view[5]}, 32'd0);
    endtask

    task automatic t_irq;
        wr_reg(2'd3, 32'h0000_0AAA);           // enable all
        src_level = 5'b01000;                  // video
        @(negedge clk);
        check("R9 not early", {31'd0, cpu_irq}, 32'd0);
        @(negedge clk);
        check("R9 raised", {31'd0, cpu_irq}, 32'd1);
        wr_reg(2'd3, 32'h0000_0040);           // mask video off
        check("R9 lag", {31'd0, cpu_irq}, 32'd1);
        @(negedge clk);
        check("R9 masked", {31'd0, cpu_irq}, 32'd0);
        src_level = 5'b00000;
        @(negedge clk);
    endtask

    task automatic t_other_addr;
        dp_pulse = 1'b1;
        @(negedge clk);
        dp_pulse = 1'b0;
        wr_reg(2'd1, 32'hFFFF_FFFF);
        wr_reg(2'd2, 32'hFFFF_FFFF);
        check("R10 mask", {26'd0, mask_view}, 32'b110111);
        check("R10 pend5", {31'd0, pend_view[5]}, 32'd1);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mask_set_clear();
        t_mask_pair_hold();
        t_level_follow();
        t_dp_latch();
        t_dp_clear();
        t_irq();
        t_other_addr();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule